// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the read timing engine on the memory side of a burst-capable flash array. It holds a 16-bit configuration word that chooses between asynchronous and clocked burst reads. For clocked bursts the word also sets the first-access delay, the spacing between words, a half-rate doubler for both delays, the timing of the ready signal, the address order inside a burst, and the burst length. A command port writes the configuration word, and a signature read at a fixed address returns it.

In asynchronous mode the read address goes straight to the array and the array data goes straight to the output. In synchronous mode a start strobe latches the start address. The sequencer then waits out the first-access latency and steps through the word addresses of the burst, presenting them to an external array model. It registers each returned word onto the output bus and drives a ready flag that marks which cycles carry a valid word. The field that picks the active clock edge is stored and brought out as a select signal for the clock steering logic, which sits outside this block. The sequencer itself runs on the rising edge of `clk`.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset the configuration word reads 0xB8C1. This means asynchronous mode (bit 15 = 1), first latency 7 (bits 13:11), no doubler (bit 10 = 0), single step (bit 9 = 0), ready aligned with data (bit 8 = 0), sequential order (bit 7 = 1), rising edge (bit 6 = 1) and a 4-word burst (bits 2:0 = 001).
- R2: `cmd_rdata` returns the stored word when `cmd_addr` is 0x05 and returns zero at any other address. Bits 14 and 5:3 always read 0, whatever was written.
- R3: A write is rejected, and the stored word left unchanged, when bits 2:0 are not 001 (4 words), 010 (8 words) or 111 (continuous), or when bits 13:11 are below 2.
- R4: In asynchronous mode (bit 15 = 1), `arr_addr` equals `rd_addr` and `dout` equals `arr_rdata` in the same cycle. `rdy` is 1, and `rd_start` starts nothing.
- R5: In synchronous mode the first word of a burst appears on `dout` after the X-th rising edge following the edge that samples `rd_start`. X is the value of bits 13:11, doubled when bit 10 is 1.
- R6: Each word stays on `dout` for Y cycles. Y is 1 when bit 9 = 0 and 2 when bit 9 = 1, and it is doubled when bit 10 is 1.
- R7: A 4-word or 8-word burst delivers exactly that many words and then drops ready. A continuous burst goes on until it is restarted.
- R8: With bit 7 = 0 (interleaved), word k reads the start address with its low log2(L) bits XORed with k.
- R9: With bit 7 = 1 (sequential), word k reads the start address with its low log2(L) bits advanced by k modulo L. A continuous burst reads start+k in both orders.
- R10: With bit 8 = 0 in synchronous mode, `rdy` is 1 exactly on the cycles in which `dout` holds a burst word.
- R11: With bit 8 = 1 in synchronous mode, `rdy` leads that pattern by one cycle. It rises one cycle before the first word and falls one cycle before invalid data.
- R12: `clk_rise_sel` follows bit 6 of the stored word.
- R13: A `rd_start` while a burst is running abandons that burst and times a new one from the new start edge.
- R14: In synchronous mode, `dout` does not change in a cycle in which aligned ready (bit 8 = 0) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Write strobe for the configuration word |
| cmd_wdata | input | 16 | Configuration word to write |
| cmd_addr | input | CW | Signature-read address |
| cmd_rdata | output | 16 | Signature-read data |
| rd_start | input | 1 | Starts a synchronous burst at `rd_addr` |
| rd_addr | input | AW | Read or burst start address |
| arr_addr | output | AW | Word address sent to the array |
| arr_rdata | input | DW | Array data for `arr_addr` |
| dout | output | DW | Output data bus |
| rdy | output | 1 | Valid-data-ready flag |
| clk_rise_sel | output | 1 | Active-edge select for clock steering |

## Verification
The bench sweeps every legal first latency together with the doubler, both step sizes, both address orders, all three lengths and both ready timings. On every cycle of each burst it compares `dout` and `rdy` with values computed arithmetically. Several faults show up directly in that sweep. A latency counter that is off by one shifts every word one cycle and breaks the first-word check. A doubler applied only to the first delay leaves words held one cycle instead of two. A wrong wrap mask sends a sequential burst outside its aligned window. A ready signal that is not led by one cycle fails on the edge cycles before the first word and after the last. The bench also writes illegal lengths and latencies, which a design without the legality test would store. It restarts a continuous burst in mid-flight, and a design that keeps the old counters there would put words on the wrong cycles.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef struct packed {
        logic       async_rd;
        logic       rsv_hi;
        logic [2:0] first_lat;
        logic       half_rate;
        logic       slow_step;
        logic       rdy_lead;
        logic       linear;
        logic       rise_edge;
        logic [2:0] rsv_lo;
        logic [2:0] blen;
    } brs_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BEAT
    } brs_state_e;

    localparam logic [2:0]  BLEN_4    = 3'b001;
    localparam logic [2:0]  BLEN_8    = 3'b010;
    localparam logic [2:0]  BLEN_CONT = 3'b111;
    localparam logic [15:0] CFG_RESET = 16'hB8C1;
    localparam logic [15:0] CFG_KEEP  = 16'hBFC7;

    function automatic logic cfg_ok(input logic [15:0] w);
        return ((w[2:0] == BLEN_4) || (w[2:0] == BLEN_8) || (w[2:0] == BLEN_CONT))
               && (w[13:11] >= 3'd2);
    endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
    import brs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output brs_cfg_t    cfg
);

    typedef struct packed {
        brs_cfg_t word;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && cfg_ok(wr_data)) begin
            r_d.word = brs_cfg_t'(wr_data & CFG_KEEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.word <= brs_cfg_t'(CFG_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg = r_q.word;

endmodule

// File: rtl/brs_timer.sv
module brs_timer
    import brs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  brs_cfg_t      cfg,
    output logic          beat_vld,
    output logic          beat_vld_nxt,
    output logic [AW-1:0] beat_idx
);

    localparam int LAT_W  = 4;
    localparam int HOLD_W = 2;

    typedef struct packed {
        brs_state_e        st;
        logic [LAT_W-1:0]  wait_cnt;
        logic [HOLD_W-1:0] hold;
        logic [AW-1:0]     idx;
    } tmr_t;

    tmr_t r_d, r_q;

    logic [LAT_W-1:0]  x_eff;
    logic [HOLD_W-1:0] hold_rl;
    logic              cont;
    logic [AW-1:0]     last_idx;

    always_comb begin
        x_eff    = cfg.half_rate ? {cfg.first_lat, 1'b0} : {1'b0, cfg.first_lat};
        hold_rl  = {cfg.slow_step & cfg.half_rate, cfg.slow_step | cfg.half_rate};
        cont     = (cfg.blen == BLEN_CONT);
        last_idx = (cfg.blen == BLEN_8) ? AW'(7) : AW'(3);

        r_d = r_q;
        case (r_q.st)
            ST_WAIT: begin
                if (r_q.wait_cnt == '0) begin
                    r_d.st   = ST_BEAT;
                    r_d.idx  = '0;
                    r_d.hold = hold_rl;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt - 1'b1;
                end
            end
            ST_BEAT: begin
                if (r_q.hold != '0) begin
                    r_d.hold = r_q.hold - 1'b1;
                end else if (!cont && (r_q.idx == last_idx)) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.idx  = r_q.idx + 1'b1;
                    r_d.hold = hold_rl;
                end
            end
            default: ;
        endcase

        if (start) begin
            r_d.st       = ST_WAIT;
            r_d.wait_cnt = x_eff - LAT_W'(2);
        end
        if (cfg.async_rd) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.wait_cnt <= '0;
            r_q.hold     <= '0;
            r_q.idx      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign beat_vld     = (r_q.st == ST_BEAT);
    assign beat_vld_nxt = (r_d.st == ST_BEAT);
    assign beat_idx     = r_q.idx;

endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
    import brs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  brs_cfg_t      cfg,
    input  logic [AW-1:0] beat_idx,
    output logic [AW-1:0] seq_addr
);

    typedef struct packed {
        logic [AW-1:0] base;
    } ag_t;

    ag_t r_d, r_q;

    logic [AW-1:0] win_mask;
    logic [AW-1:0] sum;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.base = start_addr;
        end

        win_mask = (cfg.blen == BLEN_8) ? AW'(7) : AW'(3);
        sum      = r_q.base + beat_idx;

        if (cfg.blen == BLEN_CONT) begin
            seq_addr = sum;
        end else if (cfg.linear) begin
            seq_addr = (r_q.base & ~win_mask) | (sum & win_mask);
        end else begin
            seq_addr = (r_q.base & ~win_mask) | ((r_q.base ^ beat_idx) & win_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.base <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import brs_pkg::*;
#(
    parameter int             AW       = 16,
    parameter int             DW       = 16,
    parameter int             CW       = 8,
    parameter logic [CW-1:0]  SIG_ADDR = CW'(5)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [15:0]   cmd_wdata,
    input  logic [CW-1:0] cmd_addr,
    output logic [15:0]   cmd_rdata,
    input  logic          rd_start,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] arr_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] dout,
    output logic          rdy,
    output logic          clk_rise_sel
);

    brs_cfg_t      cfg;
    logic          sync_start;
    logic          beat_vld;
    logic          beat_vld_nxt;
    logic [AW-1:0] beat_idx;
    logic [AW-1:0] seq_addr;

    typedef struct packed {
        logic [DW-1:0] dout;
        logic          rdy;
    } out_t;

    out_t o_d, o_q;

    assign sync_start = rd_start & ~cfg.async_rd;

    brs_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_we),
        .wr_data (cmd_wdata),
        .cfg     (cfg)
    );

    brs_timer #(.AW(AW)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (sync_start),
        .cfg          (cfg),
        .beat_vld     (beat_vld),
        .beat_vld_nxt (beat_vld_nxt),
        .beat_idx     (beat_idx)
    );

    brs_addr_gen #(.AW(AW)) u_ag (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (sync_start),
        .start_addr (rd_addr),
        .cfg        (cfg),
        .beat_idx   (beat_idx),
        .seq_addr   (seq_addr)
    );

    always_comb begin
        o_d = o_q;
        if (beat_vld) begin
            o_d.dout = arr_rdata;
        end
        o_d.rdy = cfg.rdy_lead ? beat_vld_nxt : beat_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.dout <= '0;
            o_q.rdy  <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign arr_addr     = (!cfg.async_rd && beat_vld) ? seq_addr : rd_addr;
    assign dout         = cfg.async_rd ? arr_rdata : o_q.dout;
    assign rdy          = cfg.async_rd | o_q.rdy;
    assign cmd_rdata    = (cmd_addr == SIG_ADDR) ? 16'(cfg) : 16'h0000;
    assign clk_rise_sel = cfg.rise_edge;

endmodule

// File: rtl/brs_chk.sv
module brs_chk
    import brs_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter int            CW       = 8,
    parameter logic [CW-1:0] SIG_ADDR = CW'(5)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_we,
    input logic [15:0]   cmd_wdata,
    input logic [CW-1:0] cmd_addr,
    input logic [15:0]   cmd_rdata,
    input logic          rd_start,
    input logic [DW-1:0] dout,
    input logic          rdy,
    input brs_cfg_t      cfg
);

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_addr == SIG_ADDR) |-> (cmd_rdata[14] == 1'b0 && cmd_rdata[5:3] == 3'b000));

    assert_legal_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.blen == BLEN_4) || (cfg.blen == BLEN_8) || (cfg.blen == BLEN_CONT))
        && (cfg.first_lat >= 3'd2));

    assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cfg_ok(cmd_wdata)) |=> $stable(cfg));

    assert_lead_low_at_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !cfg.async_rd && cfg.rdy_lead && !cmd_we) |=> !rdy);

    assert_aligned_low_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !cfg.async_rd && !cfg.rdy_lead && !cmd_we) |=> ##1 !rdy);

    assert_hold_when_not_ready_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.async_rd && !$past(cfg.async_rd) && !cfg.rdy_lead && !$past(cfg.rdy_lead) && !rdy)
        |-> $stable(dout));

endmodule

bind burst_rd_seq brs_chk #(.AW(AW), .DW(DW), .CW(CW), .SIG_ADDR(SIG_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .cmd_addr  (cmd_addr),
    .cmd_rdata (cmd_rdata),
    .rd_start  (rd_start),
    .dout      (dout),
    .rdy       (rdy),
    .cfg       (cfg)
);

// File: tb/burst_rd_seq_tb.sv
`timescale 1ns/1ps
module burst_rd_seq_tb;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [15:0]   cmd_wdata = '0;
    logic [CW-1:0] cmd_addr = 8'h05;
    logic [15:0]   cmd_rdata;
    logic          rd_start = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] dout;
    logic          rdy;
    logic          clk_rise_sel;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string ctx    = "";

    always #2 clk = ~clk;

    burst_rd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_addr(cmd_addr), .cmd_rdata(cmd_rdata), .rd_start(rd_start),
        .rd_addr(rd_addr), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .dout(dout), .rdy(rdy), .clk_rise_sel(clk_rise_sel)
    );

    // array model: data is a fixed bijection of the address
    assign arr_rdata = arr_addr ^ 16'hA5C3;

    function automatic logic [15:0] mem(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", ctx, tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] base, input int k,
                                             input bit lin, input int blsel);
        int len;
        int off;
        if (blsel == 2) return base + 16'(k);
        len = (blsel == 1) ? 8 : 4;
        off = int'(base) % len;
        if (lin) return base - 16'(off) + 16'((off + k) % len);
        return base - 16'(off) + 16'(off ^ k);
    endfunction

    function automatic bit vld(input int t, input int xe, input int ye, input int nb, input bit cont);
        if (t < xe) return 1'b0;
        if (cont) return 1'b1;
        return ((t - xe) / ye) < nb;
    endfunction

    task automatic run_sync(input int x, input bit dbl, input bit y2, input bit early,
                            input bit lin, input int blsel, input logic [15:0] base, input bit rise);
        logic [15:0] w;
        logic [2:0]  bl;
        int xe, ye, nb, k, last_t;
        bit cont, v;
        string tg;
        bl   = (blsel == 0) ? 3'b001 : (blsel == 1) ? 3'b010 : 3'b111;
        cont = (blsel == 2);
        w    = {1'b0, 1'b0, 3'(x), dbl, y2, early, lin, rise, 3'b000, bl};
        wr_cfg(w);
        chk("R2 readback", cmd_rdata, w);
        chk("R12 edge select", clk_rise_sel, rise);
        xe = dbl ? 2 * x : x;
        ye = (y2 ? 2 : 1) * (dbl ? 2 : 1);
        nb = cont ? 10 : ((blsel == 1) ? 8 : 4);
        last_t = xe + nb * ye + 2;
        @(negedge clk);
        rd_addr  = base;
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        for (int t = 1; t <= last_t; t++) begin
            @(negedge clk);
            v = vld(t, xe, ye, nb, cont);
            if (early) tg = "R11 lead ready";
            else       tg = "R10 aligned ready";
            if (!cont && t == xe + nb * ye) tg = {tg, " R7 end of burst"};
            chk(tg, rdy, early ? vld(t + 1, xe, ye, nb, cont) : v);
            if (v) begin
                k = (t - xe) / ye;
                if (t == xe)    tg = "R5 first word";
                else if (lin)   tg = "R9 R6 sequential word";
                else            tg = "R8 R6 interleaved word";
                chk(tg, dout, mem(exp_addr(base, k, lin, blsel)));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int run;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset word", cmd_rdata, 16'hB8C1);
        chk("R1 reset ready", rdy, 1'b1);
        chk("R1 reset edge select", clk_rise_sel, 1'b1);
        cmd_addr = 8'h06;
        #1 chk("R2 other address reads zero", cmd_rdata, 16'h0000);
        cmd_addr = 8'h05;

        // asynchronous pass-through, start ignored
        rd_addr = 16'h1234;
        #1 chk("R4 async array address", arr_addr, 16'h1234);
        chk("R4 async data", dout, mem(16'h1234));
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rd_addr = 16'h0400 + 16'(i * 3);
            #1 chk("R4 async start ignored ready", rdy, 1'b1);
            chk("R4 async start ignored data", dout, mem(16'h0400 + 16'(i * 3)));
            @(negedge clk);
        end

        // rejected writes and reserved bits
        wr_cfg(16'hB8C3);
        chk("R3 bad length rejected", cmd_rdata, 16'hB8C1);
        wr_cfg(16'h88C1);
        chk("R3 latency one rejected", cmd_rdata, 16'hB8C1);
        wr_cfg(16'h80C4);
        chk("R3 reserved length code rejected", cmd_rdata, 16'hB8C1);
        wr_cfg(16'hFFFF);
        chk("R2 reserved bits read zero", cmd_rdata, 16'hBFC7);
        chk("R12 edge select set", clk_rise_sel, 1'b1);
        wr_cfg(16'h9001);
        chk("R12 edge select cleared", clk_rise_sel, 1'b0);

        // full sweep of synchronous configurations
        run = 0;
        for (int x = 2; x <= 7; x++)
            for (int d = 0; d < 2; d++)
                for (int y = 0; y < 2; y++)
                    for (int e = 0; e < 2; e++)
                        for (int s = 0; s < 2; s++)
                            for (int b = 0; b < 3; b++) begin
                                run_sync(x, d[0], y[0], e[0], s[0], b,
                                         16'h1235 + 16'(run * 16'h0137), run[0]);
                                run++;
                            end

        // restart of a running continuous burst
        ctx = "R13 restart";
        run_sync(3, 1'b0, 1'b0, 1'b0, 1'b1, 2, 16'h7FFC, 1'b1);
        run_sync(4, 1'b1, 1'b0, 1'b1, 1'b0, 0, 16'h2226, 1'b1);
        ctx = "";

        // back to asynchronous mode
        wr_cfg(16'hB8C1);
        rd_addr = 16'hBEEF;
        #1 chk("R4 async after sync ready", rdy, 1'b1);
        chk("R4 async after sync data", dout, mem(16'hBEEF));
        chk("R4 async after sync address", arr_addr, 16'hBEEF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule